// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller lets an 8-bit core reach off-chip memory over a multiplexed pin bus. The low address byte and the data byte share one 8-bit port, and the high address byte has its own port. Three control pins carry an address-latch strobe (active high) and the read and write strobes (active low). An external transparent latch holds the low address byte: it captures the byte on the falling edge of the latch strobe, and the memory then sees the full address while data moves over the shared port.

Each core request is classified by its address. Addresses at or below the parameter `INT_TOP` belong to internal memory. Addresses above it are external. While the controller is enabled it owns all of its pins. Every access runs an address phase and then a data phase, which can be stretched by a wait-state count of 0 to 3. Internal accesses still show address, data and latch-strobe activity on the pins, but they never move the read or write strobes. While disabled, the pins follow the ordinary port output and direction values. A request then completes at once, and if its address lies above the boundary it is flagged as unmapped, with no bus activity.

The core issues single-cycle requests while `busy` is low. It receives a one-cycle `done` pulse, together with read data and flags.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset, with the controller enabled, `busy` and `done` are low, `pin_ale` is low, `pin_rd_n` and `pin_wr_n` are high, and the shared and high address ports are released (all output-enable bits 0).
- R2: An access whose address is greater than `INT_TOP` is external, and any other address is internal. `rsp_ext` reports the class during the `done` cycle.
- R3: The cycle after a request is accepted is the address phase, lasting exactly one cycle. In it, `pin_ale` is 1, the shared port drives `addr[7:0]` with all enable bits set, and neither strobe is low.
- R4: `pin_ale` is low on every data-phase cycle. `pin_ahi_out` carries `addr[15:8]`, with all enable bits set, through both phases.
- R5: In an external write, `pin_wr_n` is low and `pin_rd_n` is high on every data-phase cycle, and the shared port drives `wdata` with all enable bits set.
- R6: In an external read, `pin_rd_n` is low and `pin_wr_n` is high on every data-phase cycle, and the shared port is released. The value on `pin_ad_in` during the last data-phase cycle appears on `rdata` in the `done` cycle.
- R7: The data phase lasts 1 + `ws` cycles, with `ws` (0 to 3) taken when the request is accepted.
- R8: An internal access while enabled drives the address phase and the latch strobe as usual, but `pin_rd_n` and `pin_wr_n` stay high for the whole access, and `rdata` reads 0.
- R9: `done` is high for exactly one cycle, the cycle after the last data-phase cycle. A request raised while `busy` is high is ignored.
- R10: While `en` is 0, each pin and its enable follow the matching `port_*` input (control bit order: 0 = latch strobe, 1 = read strobe, 2 = write strobe). A request then produces `done` on the next cycle, with `rsp_unmapped` = 1 exactly when the address is above `INT_TOP`, `rsp_ext` = 0, and no latch strobe.
- R11: Between accesses while enabled, both strobes are high, `pin_ale` is low and the shared port is released, and all control-pin enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Controller owns the pins when 1 |
| ws | input | 2 | Wait-state count for the next access |
| req | input | 1 | Single-cycle access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with done |
| rsp_ext | output | 1 | Completed access was external |
| rsp_unmapped | output | 1 | Completed access hit the unmapped range |
| pin_ad_in | input | 8 | Shared address/data port, input side |
| pin_ad_out | output | 8 | Shared address/data port, output value |
| pin_ad_oe | output | 8 | Shared port output enables |
| pin_ahi_out | output | 8 | High address port value |
| pin_ahi_oe | output | 8 | High address port output enables |
| pin_ale | output | 1 | Address latch strobe pin |
| pin_rd_n | output | 1 | Read strobe pin |
| pin_wr_n | output | 1 | Write strobe pin |
| pin_ctl_oe | output | 3 | Control pin output enables |
| port_ad_out | input | 8 | Normal port value, shared pins |
| port_ad_oe | input | 8 | Normal direction, shared pins |
| port_ahi_out | input | 8 | Normal port value, high pins |
| port_ahi_oe | input | 8 | Normal direction, high pins |
| port_ctl_out | input | 3 | Normal port value, control pins |
| port_ctl_oe | input | 3 | Normal direction, control pins |

## Verification
The bench builds the controller with its defaults: a 16-bit address, an 8-bit data byte, a 2-bit wait-state field and an internal boundary at 0x10FF. Because the wait count is a port, one build sweeps every data-phase length from 1 to 4 cycles. The default boundary puts 0x10FF and 0x1100 on opposite sides of the classifier, so both edges are exercised in both the enabled and the disabled modes.

// File: rtl/xmem_pkg.sv
// Shared types for the external memory bus controller.
// Assumes: none; holds only the sequencer state encoding.
package xmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } xm_state_t;
endpackage

// File: rtl/xmem_decode.sv
// Address classifier: flags an address above the internal boundary as external.
// Assumes: INT_TOP fits in ADDR_W bits.
module xmem_decode #(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] INT_TOP = 16'h10FF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ext
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(INT_TOP);

    // Compare against the boundary.
    always_comb begin
        is_ext = (addr > TOP);
    end
endmodule

// File: rtl/xmem_seq.sv
// Access sequencer: runs the address phase, the strobed data phase with wait
// states, and the completion pulse. It also completes requests made while disabled.
// Assumes: req is only honoured in idle; ws is sampled at acceptance.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WS_W-1:0]   ws,
    input  logic              is_ext,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              rsp_ext,
    output logic              rsp_unmapped,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ahi_out,
    output logic              ahi_oe
);
    localparam int HI_W = ADDR_W - DATA_W;

    xm_state_t         state;
    logic [WS_W-1:0]   cnt;
    logic [WS_W-1:0]   lat_ws;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wd;
    logic              lat_we;
    logic              lat_ext;
    logic              done_q;
    logic              ext_q;
    logic              unm_q;
    logic [DATA_W-1:0] rdata_q;

    // State, latched request and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            lat_ws   <= '0;
            lat_addr <= '0;
            lat_wd   <= '0;
            lat_we   <= 1'b0;
            lat_ext  <= 1'b0;
            done_q   <= 1'b0;
            ext_q    <= 1'b0;
            unm_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        lat_addr <= addr;
                        lat_wd   <= wdata;
                        lat_we   <= we;
                        lat_ext  <= is_ext;
                        lat_ws   <= ws;
                        if (en) begin
                            state <= ST_ADDR;
                        end else begin
                            done_q  <= 1'b1;
                            ext_q   <= 1'b0;
                            unm_q   <= is_ext;
                            rdata_q <= '0;
                        end
                    end
                end
                ST_ADDR: begin
                    state <= ST_DATA;
                    cnt   <= lat_ws;
                end
                ST_DATA: begin
                    if (cnt == '0) begin
                        state   <= ST_IDLE;
                        done_q  <= 1'b1;
                        ext_q   <= lat_ext;
                        unm_q   <= 1'b0;
                        rdata_q <= (!lat_we && lat_ext) ? ad_in : '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pin-side values decoded from the phase and the latched request.
    always_comb begin
        busy         = (state != ST_IDLE);
        done         = done_q;
        rdata        = rdata_q;
        rsp_ext      = ext_q;
        rsp_unmapped = unm_q;
        ale          = (state == ST_ADDR);
        rd_n         = !((state == ST_DATA) && !lat_we && lat_ext);
        wr_n         = !((state == ST_DATA) &&  lat_we && lat_ext);
        ad_out       = (state == ST_ADDR) ? lat_addr[DATA_W-1:0] : lat_wd;
        ad_oe        = (state == ST_ADDR) || ((state == ST_DATA) && lat_we);
        ahi_out      = lat_addr[ADDR_W-1:DATA_W];
        ahi_oe       = (state != ST_IDLE);
    end

    // The two strobes never go low together.
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // Internal accesses never move a strobe.
    assert_int_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lat_ext) |-> (rd_n && wr_n));

    // The latch strobe lasts one cycle.
    assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // A strobe only falls right after the latch strobe.
    assert_rd_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ale));
    assert_wr_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(ale));

    // Completion is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // The data phase never outlasts the longest wait count.
    assert_ws_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (cnt <= lat_ws));
endmodule

// File: rtl/xmem_pinmux.sv
// Pin override: hands the pins to the sequencer while enabled, otherwise
// passes the ordinary port values and directions through.
// Assumes: control bit order 0 = latch strobe, 1 = read, 2 = write.
module xmem_pinmux #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] s_ad_out,
    input  logic              s_ad_oe,
    input  logic [HI_W-1:0]   s_ahi_out,
    input  logic              s_ahi_oe,
    input  logic              s_ale,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic [DATA_W-1:0] port_ad_out,
    input  logic [DATA_W-1:0] port_ad_oe,
    input  logic [HI_W-1:0]   port_ahi_out,
    input  logic [HI_W-1:0]   port_ahi_oe,
    input  logic [2:0]        port_ctl_out,
    input  logic [2:0]        port_ctl_oe,
    output logic [DATA_W-1:0] pin_ad_out,
    output logic [DATA_W-1:0] pin_ad_oe,
    output logic [HI_W-1:0]   pin_ahi_out,
    output logic [HI_W-1:0]   pin_ahi_oe,
    output logic              pin_ale,
    output logic              pin_rd_n,
    output logic              pin_wr_n,
    output logic [2:0]        pin_ctl_oe
);
    // Select the pin owner.
    always_comb begin
        if (en) begin
            pin_ad_out  = s_ad_out;
            pin_ad_oe   = {DATA_W{s_ad_oe}};
            pin_ahi_out = s_ahi_out;
            pin_ahi_oe  = {HI_W{s_ahi_oe}};
            pin_ale     = s_ale;
            pin_rd_n    = s_rd_n;
            pin_wr_n    = s_wr_n;
            pin_ctl_oe  = 3'b111;
        end else begin
            pin_ad_out  = port_ad_out;
            pin_ad_oe   = port_ad_oe;
            pin_ahi_out = port_ahi_out;
            pin_ahi_oe  = port_ahi_oe;
            pin_ale     = port_ctl_out[0];
            pin_rd_n    = port_ctl_out[1];
            pin_wr_n    = port_ctl_out[2];
            pin_ctl_oe  = port_ctl_oe;
        end
    end
endmodule

// File: rtl/xmem_bus_ctrl.sv
// Top: multiplexed external memory bus controller. It ties together the
// classifier, the sequencer and the pin override.
// Assumes: DATA_W < ADDR_W; the core sends single-cycle requests while not busy.
module xmem_bus_ctrl #(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter int          WS_W    = 2,
    parameter logic [15:0] INT_TOP = 16'h10FF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [WS_W-1:0]          ws,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rsp_ext,
    output logic                     rsp_unmapped,
    input  logic [DATA_W-1:0]        pin_ad_in,
    output logic [DATA_W-1:0]        pin_ad_out,
    output logic [DATA_W-1:0]        pin_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] pin_ahi_out,
    output logic [ADDR_W-DATA_W-1:0] pin_ahi_oe,
    output logic                     pin_ale,
    output logic                     pin_rd_n,
    output logic                     pin_wr_n,
    output logic [2:0]               pin_ctl_oe,
    input  logic [DATA_W-1:0]        port_ad_out,
    input  logic [DATA_W-1:0]        port_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] port_ahi_out,
    input  logic [ADDR_W-DATA_W-1:0] port_ahi_oe,
    input  logic [2:0]               port_ctl_out,
    input  logic [2:0]               port_ctl_oe
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic              is_ext;
    logic [DATA_W-1:0] s_ad_out;
    logic              s_ad_oe;
    logic [HI_W-1:0]   s_ahi_out;
    logic              s_ahi_oe;
    logic              s_ale;
    logic              s_rd_n;
    logic              s_wr_n;

    xmem_decode #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) u_dec (
        .addr   (addr),
        .is_ext (is_ext)
    );

    xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .req          (req),
        .we           (we),
        .addr         (addr),
        .wdata        (wdata),
        .ws           (ws),
        .is_ext       (is_ext),
        .ad_in        (pin_ad_in),
        .busy         (busy),
        .done         (done),
        .rdata        (rdata),
        .rsp_ext      (rsp_ext),
        .rsp_unmapped (rsp_unmapped),
        .ale          (s_ale),
        .rd_n         (s_rd_n),
        .wr_n         (s_wr_n),
        .ad_out       (s_ad_out),
        .ad_oe        (s_ad_oe),
        .ahi_out      (s_ahi_out),
        .ahi_oe       (s_ahi_oe)
    );

    xmem_pinmux #(.DATA_W(DATA_W), .HI_W(HI_W)) u_mux (
        .en           (en),
        .s_ad_out     (s_ad_out),
        .s_ad_oe      (s_ad_oe),
        .s_ahi_out    (s_ahi_out),
        .s_ahi_oe     (s_ahi_oe),
        .s_ale        (s_ale),
        .s_rd_n       (s_rd_n),
        .s_wr_n       (s_wr_n),
        .port_ad_out  (port_ad_out),
        .port_ad_oe   (port_ad_oe),
        .port_ahi_out (port_ahi_out),
        .port_ahi_oe  (port_ahi_oe),
        .port_ctl_out (port_ctl_out),
        .port_ctl_oe  (port_ctl_oe),
        .pin_ad_out   (pin_ad_out),
        .pin_ad_oe    (pin_ad_oe),
        .pin_ahi_out  (pin_ahi_out),
        .pin_ahi_oe   (pin_ahi_oe),
        .pin_ale      (pin_ale),
        .pin_rd_n     (pin_rd_n),
        .pin_wr_n     (pin_wr_n),
        .pin_ctl_oe   (pin_ctl_oe)
    );

    // While enabled, the controller owns every control pin.
    assert_ctl_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !busy) |-> (pin_ctl_oe == 3'b111 && pin_rd_n && pin_wr_n && !pin_ale));

    // A request made while disabled completes on the next cycle.
    assert_off_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy && req) |=> done);
endmodule

// File: tb/xmem_bus_ctrl_test.sv
// Directed bench for the external memory bus controller.
module xmem_bus_ctrl_test;
    localparam logic [15:0] TOP = 16'h10FF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [1:0] ws = '0;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       busy, done, rsp_ext, rsp_unmapped;
    logic [7:0] rdata;
    logic [7:0] pin_ad_in = '0;
    logic [7:0] pin_ad_out, pin_ad_oe, pin_ahi_out, pin_ahi_oe;
    logic       pin_ale, pin_rd_n, pin_wr_n;
    logic [2:0] pin_ctl_oe;
    logic [7:0] port_ad_out = 8'h5A, port_ad_oe = 8'h0F;
    logic [7:0] port_ahi_out = 8'hC3, port_ahi_oe = 8'hF0;
    logic [2:0] port_ctl_out = 3'b101, port_ctl_oe = 3'b010;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xmem_bus_ctrl uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ale", pin_ale, 0);
        chk("R1 rd_n", pin_rd_n, 1);
        chk("R1 wr_n", pin_wr_n, 1);
        chk("R1 ad_oe", pin_ad_oe, 0);
        chk("R1 ahi_oe", pin_ahi_oe, 0);
        chk("R11 ctl_oe", pin_ctl_oe, 3'b111);
    endtask

    // R2-R9, R11: one enabled access, checked phase by phase.
    task automatic t_access(input logic w, input logic [15:0] a, input logic [7:0] d,
                            input logic [1:0] n, input logic [7:0] rv);
        logic e;
        e = (a > TOP);
        @(negedge clk);
        ws = n; we = w; addr = a; wdata = d; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R3 ale high", pin_ale, 1);
        chk("R3 ad addr lo", pin_ad_out, a[7:0]);
        chk("R3 ad oe", pin_ad_oe, 8'hFF);
        chk("R3 strobes idle", {pin_rd_n, pin_wr_n}, 2'b11);
        chk("R4 ahi addr", pin_ahi_out, a[15:8]);
        chk("R4 ahi oe", pin_ahi_oe, 8'hFF);
        for (int k = 0; k <= int'(n); k++) begin
            @(negedge clk);
            pin_ad_in = (k == int'(n)) ? rv : ~rv;
            chk("R4 ale low in data", pin_ale, 0);
            chk("R4 ahi held", pin_ahi_out, a[15:8]);
            chk("R7 no early done", done, 0);
            if (e && w) begin
                chk("R5 wr_n low", pin_wr_n, 0);
                chk("R5 rd_n high", pin_rd_n, 1);
                chk("R5 ad wdata", pin_ad_out, d);
                chk("R5 ad oe", pin_ad_oe, 8'hFF);
            end else if (e) begin
                chk("R6 rd_n low", pin_rd_n, 0);
                chk("R6 wr_n high", pin_wr_n, 1);
                chk("R6 ad released", pin_ad_oe, 0);
            end else begin
                chk("R8 strobes quiet", {pin_rd_n, pin_wr_n}, 2'b11);
            end
        end
        @(negedge clk);
        chk("R9 done", done, 1);
        chk("R7 done timing busy", busy, 0);
        chk("R2 rsp_ext", rsp_ext, e);
        if (!w) chk(e ? "R6 rdata" : "R8 rdata zero", rdata, e ? rv : 8'h00);
        chk("R11 ale rest", pin_ale, 0);
        chk("R11 strobes rest", {pin_rd_n, pin_wr_n}, 2'b11);
        chk("R11 ad released", pin_ad_oe, 0);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
    endtask

    // R9: a request during an access is dropped.
    task automatic t_busy_ignore();
        @(negedge clk);
        ws = 0; we = 1; addr = 16'h3000; wdata = 8'h11; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        addr = 16'h4444; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R9 first done", done, 1);
        @(negedge clk);
        chk("R9 ignored no ale", pin_ale, 0);
        chk("R9 ignored not busy", busy, 0);
        @(negedge clk);
        chk("R9 ignored no done", done, 0);
    endtask

    // R10: disabled pass-through and unmapped upper range.
    task automatic t_disabled();
        @(negedge clk);
        en = 1'b0;
        #1;
        chk("R10 ad out", pin_ad_out, port_ad_out);
        chk("R10 ad oe", pin_ad_oe, port_ad_oe);
        chk("R10 ahi out", pin_ahi_out, port_ahi_out);
        chk("R10 ahi oe", pin_ahi_oe, port_ahi_oe);
        chk("R10 ctl", {pin_wr_n, pin_rd_n, pin_ale}, port_ctl_out);
        chk("R10 ctl oe", pin_ctl_oe, port_ctl_oe);
        @(negedge clk);
        we = 0; addr = 16'h1100; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R10 done", done, 1);
        chk("R10 unmapped above", rsp_unmapped, 1);
        chk("R10 ext zero", rsp_ext, 0);
        chk("R10 ale follows port", pin_ale, port_ctl_out[0]);
        @(negedge clk);
        addr = 16'h10FF; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R10 done internal", done, 1);
        chk("R10 mapped at boundary", rsp_unmapped, 0);
        @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_access(1'b1, 16'h1100, 8'hA5, 2'd0, 8'h00); // R5 boundary+1, no wait
        t_access(1'b0, 16'hBEEF, 8'h00, 2'd0, 8'h3C); // R6
        t_access(1'b0, 16'h8001, 8'h00, 2'd3, 8'hC7); // R7 max wait
        t_access(1'b1, 16'hFFFF, 8'h96, 2'd2, 8'h00); // R7
        t_access(1'b1, 16'h10FF, 8'h77, 2'd1, 8'h00); // R8 boundary internal
        t_access(1'b0, 16'h0200, 8'h00, 2'd0, 8'hE1); // R8 internal read
        t_busy_ignore();
        t_disabled();
        t_access(1'b0, 16'h2345, 8'h00, 2'd1, 8'h5E); // re-enabled
        finish_run();
    end
endmodule